// File: doc/BRIEF.md
# Banked GPIO Register Block with Bit-Masked Writes

This block holds the pin control state for one bank of general-purpose pins, split into ports of eight pins each (four ports, 32 pins by default). Software reaches it over a plain 32-bit memory-mapped bus with a single write strobe and a combinational read path. Each port has three writable byte registers: a GPIO-select bit per pin, a driver-enable bit per pin and an output-level bit per pin. A fourth, read-only register shows the pin state. Pin n of the bank is bit n of the pad vectors, so pin n belongs to port n/8, bit n%8.

Every writable register can be written in two ways. A plain write replaces the whole byte. A second, masked copy of the register map sits at a fixed upper offset. A write to that copy uses the second byte of the bus word as a per-bit select, so one store can set or clear any single pin with no read-modify-write. Pad inputs pass through two flip-flops before software can read them. For pins whose driver is enabled, software reads back the level it drives instead of the pad.

Top module: `gpio_bank_regs`

## Requirements
- R1: After reset, every GPIO-select, driver-enable and output-level bit is 0. Every pad driver is released and every plain register reads 0.
- R2: A plain write to a writable register loads bus_wdata[7:0] into the addressed port's byte and ignores bits 31:8. Reads of any register return zero in bits 31:8.
- R3: The plain register of kind g for port p sits at byte address 0x10*g + 4*p. Kind 0 is GPIO-select, kind 1 is driver-enable, kind 2 is output-level and kind 3 is the read-only input view.
- R4: The masked copy of kind g for port p sits at MASK_OFS + 0x10*g + 4*p, with MASK_OFS = 0x80 by default. A write there updates only the bits whose select bit in bus_wdata[15:8] is 1, each to the matching bit of bus_wdata[7:0]. A select byte of zero changes nothing.
- R5: pad_out carries each pin's output-level bit. pad_oe for a pin is 1 only when both its GPIO-select bit and its driver-enable bit are 1.
- R6: Reading the input view returns the output-level bit for pins whose driver-enable bit is 1. For the other pins it returns the pad level sampled through two flip-flops, so a pad change is read after the second rising clock edge.
- R7: Writes to either copy of the input view, to addresses with bits 1:0 non-zero and to addresses outside both maps change no state. Reads of such addresses return 0.
- R8: A read of the masked copy of a writable register returns the same byte as its plain copy.
- R9: Pin n is controlled and observed at bit n of pad_in, pad_out and pad_oe, where n = 8*port + bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, acts on the rising edge |
| bus_addr | input | ADDR_W (12) | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data; bits 15:8 select bits in masked writes |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pad_in | input | PORTS*PINS (32) | Pad levels, asynchronous |
| pad_out | output | PORTS*PINS (32) | Level driven on each pad |
| pad_oe | output | PORTS*PINS (32) | Pad driver enable; 0 means high-Z |

## Verification
On every cycle, the assertions check three things. Plain writes load exactly the low byte. Masked writes leave unselected bits untouched. Idle cycles and writes to the input view leave all state unchanged. They also check that the synchronized input lags the pads by two edges and that read-back of driven pins shows their output level. What the assertions cannot show is whether the address map is correct as a whole: that each kind and port lands on the right address, that the masked copy mirrors the plain one on reads, that pin n appears at pad bit n, and that misaligned or out-of-map accesses are harmless. The bench's scenarios show these by comparing every cycle against a behavioural model and by directed reads with values worked out by hand.

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs #(
  parameter int                PORTS    = 4,
  parameter int                PINS     = 8,
  parameter int                ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] MASK_OFS = 'h80
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_wr,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [31:0]             bus_wdata,
  output logic [31:0]             bus_rdata,
  input  logic [PORTS*PINS-1:0]   pad_in,
  output logic [PORTS*PINS-1:0]   pad_out,
  output logic [PORTS*PINS-1:0]   pad_oe
);
  localparam int NPIN = PORTS * PINS;
  localparam int SEL_LSB = 8;

  // rf[0] GPIO-select, rf[1] driver-enable, rf[2] output-level
  logic [2:0][PORTS-1:0][PINS-1:0] rf;
  logic [NPIN-1:0] sync1, sync2;
  logic [PORTS-1:0][PINS-1:0] in_view;

  logic [1:0] grp, prt;
  logic aligned, port_ok, plain_hit, mask_hit;
  logic [PINS-1:0] sel, val, rd_byte;

  assign grp       = bus_addr[5:4];
  assign prt       = bus_addr[3:2];
  assign aligned   = bus_addr[1:0] == 2'b00;
  assign port_ok   = 32'(prt) < PORTS;
  assign plain_hit = aligned && port_ok && bus_addr[ADDR_W-1:6] == '0;
  assign mask_hit  = aligned && port_ok && bus_addr[ADDR_W-1:6] == MASK_OFS[ADDR_W-1:6];
  assign sel       = bus_wdata[SEL_LSB +: PINS];
  assign val       = bus_wdata[PINS-1:0];

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata[31:SEL_LSB+PINS] ^ ^bus_wdata[SEL_LSB-1:PINS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rf <= '0;
    end else if (bus_wr) begin
      for (int g = 0; g < 3; g++) begin
        if (32'(grp) == g) begin
          if (plain_hit)
            rf[g][prt] <= val;
          else if (mask_hit)
            rf[g][prt] <= (rf[g][prt] & ~sel) | (val & sel);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= pad_in;
      sync2 <= sync1;
    end
  end

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    assign pad_out[p*PINS +: PINS] = rf[2][p];
    assign pad_oe[p*PINS +: PINS]  = rf[0][p] & rf[1][p];
    assign in_view[p] = (rf[1][p] & rf[2][p]) | (~rf[1][p] & sync2[p*PINS +: PINS]);
  end

  always_comb begin
    case (grp)
      2'd0:    rd_byte = rf[0][prt];
      2'd1:    rd_byte = rf[1][prt];
      2'd2:    rd_byte = rf[2][prt];
      default: rd_byte = in_view[prt];
    endcase
    bus_rdata = '0;
    if (plain_hit || (mask_hit && grp != 2'd3))
      bus_rdata[PINS-1:0] = rd_byte;
  end

  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             age <= '0;
    else if (age != 2'd2)   age <= age + 2'd1;
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(rf)); // R7
  AST_INPUT_WRITE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && grp == 2'd3) |=> $stable(rf)); // R7
  AST_SYNC_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd2) |-> sync2 == $past(pad_in, 2)); // R6

  for (genvar p = 0; p < PORTS; p++) begin : g_chk
    AST_DRIVEN_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
      (plain_hit && grp == 2'd3 && 32'(prt) == p) |->
        ((bus_rdata[PINS-1:0] ^ rf[2][p]) & rf[1][p]) == '0); // R6
    for (genvar g = 0; g < 3; g++) begin : g_kind
      AST_PLAIN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && plain_hit && 32'(grp) == g && 32'(prt) == p) |=>
          rf[g][p] == $past(bus_wdata[PINS-1:0])); // R2
      AST_MASK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && mask_hit && 32'(grp) == g && 32'(prt) == p) |=>
          ((rf[g][p] ^ $past(rf[g][p])) & ~$past(bus_wdata[SEL_LSB +: PINS])) == '0); // R4
    end
  end
endmodule

// File: tb/sim_gpio_bank_regs.sv
module sim_gpio_bank_regs;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_wr = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = 32'hA5A5_5A5A;
  logic [31:0] pad_out, pad_oe;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gpio_bank_regs u0 (.clk, .rst_n, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
                     .pad_in, .pad_out, .pad_oe);

  // behavioural reference
  logic [7:0]  m_reg [3][4];
  logic [31:0] m_s1, m_s2;

  function automatic logic [31:0] m_read(input logic [11:0] a);
    int off, g, p;
    logic [7:0] b;
    if (a[1:0] != 0) return 0;
    if (a < 12'h040) off = a;
    else if (a >= 12'h080 && a < 12'h0B0) off = a - 12'h080;
    else return 0;
    g = off / 16; p = (off % 16) / 4;
    if (g < 3) return {24'd0, m_reg[g][p]};
    for (int i = 0; i < 8; i++)
      b[i] = m_reg[1][p][i] ? m_reg[2][p][i] : m_s2[p*8+i];
    return {24'd0, b};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_reg[g, p]) m_reg[g][p] = 0;
      m_s1 = 0; m_s2 = 0;
    end else begin
      if (bus_wr && bus_addr[1:0] == 0) begin
        int off, g, p;
        if (bus_addr < 12'h030) begin
          off = bus_addr; g = off / 16; p = (off % 16) / 4;
          m_reg[g][p] = bus_wdata[7:0];
        end else if (bus_addr >= 12'h080 && bus_addr < 12'h0B0) begin
          off = bus_addr - 12'h080; g = off / 16; p = (off % 16) / 4;
          m_reg[g][p] = (m_reg[g][p] & ~bus_wdata[15:8]) | (bus_wdata[7:0] & bus_wdata[15:8]);
        end
      end
      m_s2 = m_s1;
      m_s1 = pad_in;
    end
  end

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #3;
    if (rst_n && !done) begin
      logic [31:0] e_oe, e_out;
      for (int p = 0; p < 4; p++) begin
        e_out[p*8 +: 8] = m_reg[2][p];
        e_oe[p*8 +: 8]  = m_reg[0][p] & m_reg[1][p];
      end
      check(pad_out, e_out, "R5 model pad_out");
      check(pad_oe, e_oe, "R5 model pad_oe");
      check(bus_rdata, m_read(bus_addr), "R3 model read");
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); bus_wr = 0; bus_addr = a;
    #1 check(bus_rdata, exp, tag);
  endtask

  initial begin
    #800000;
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(pad_oe, 32'h0, "R1 reset pad_oe");
    check(pad_out, 32'h0, "R1 reset pad_out");
    rst_n = 1;
    rd(12'h000, 32'h0, "R1 reset select p0");
    rd(12'h024, 32'h0, "R1 reset level p1");
    repeat (3) @(negedge clk);
    rd(12'h030, 32'h5A, "R6 input p0 from pad");

    wr(12'h000, 32'hFFFF_FF3C);
    rd(12'h000, 32'h3C, "R2 plain load low byte");
    wr(12'h014, 32'h0000_000F);
    wr(12'h004, 32'h0000_00FF);
    rd(12'h014, 32'h0F, "R3 enable p1 address");
    check(pad_oe, 32'h0000_0F00, "R5 pad_oe p1 select&enable");
    wr(12'h028, 32'h0000_0081);
    rd(12'h028, 32'h81, "R3 level p2 address");
    check(pad_out[23:16], 32'h81, "R5 pad_out p2");

    wr(12'h0A8, 32'h0000_0102);
    rd(12'h028, 32'h80, "R4 masked clear bit0");
    wr(12'h0A8, 32'h0000_4040);
    rd(12'h028, 32'hC0, "R4 masked set bit6");
    wr(12'h0A8, 32'h0000_00FF);
    rd(12'h028, 32'hC0, "R4 zero select no change");
    rd(12'h0A8, 32'hC0, "R8 masked copy read");

    wr(12'h018, 32'h0000_00F0);
    rd(12'h038, 32'hC5, "R6 driven bits read back level");

    @(negedge clk); bus_addr = 12'h030; pad_in[7:0] = 8'hFF;
    #1 check(bus_rdata, 32'h5A, "R6 no edge yet");
    @(posedge clk); #2 check(bus_rdata, 32'h5A, "R6 one edge");
    @(posedge clk); #2 check(bus_rdata, 32'hFF, "R6 two edges");

    wr(12'h030, 32'h0000_00FF);
    wr(12'h0B0, 32'h0000_FF00);
    wr(12'h001, 32'h0000_0000);
    wr(12'h040, 32'h0000_0000);
    wr(12'h100, 32'h0000_0000);
    rd(12'h000, 32'h3C, "R7 select p0 untouched");
    rd(12'h018, 32'hF0, "R7 enable p2 untouched");
    rd(12'h040, 32'h0, "R7 unmapped read");
    rd(12'h0B0, 32'h0, "R7 masked input read");
    rd(12'h002, 32'h0, "R7 misaligned read");

    wr(12'h0AC, 32'h0000_2020);
    @(negedge clk);
    check(pad_out, 32'h20C0_0000, "R9 pin 29 level");
    wr(12'h00C, 32'h0000_0020);
    wr(12'h09C, 32'h0000_2020);
    @(negedge clk);
    check(pad_oe, 32'h2000_0F00, "R9 pin 29 driver");

    repeat (4) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule